// File: doc/BRIEF.md
# Length-Prefixed Serial Boot Loader

This block sits behind a byte-wide serial receiver and loads two images into memory before handing over control. Each image arrives as one transaction: a four-byte length prefix followed by that many payload bytes. The first transaction is stored contiguously from a code region base address, and the second from a data region base address. The prefix bytes are stored too, ahead of the payload. When the second transaction ends, the block raises a one-cycle start pulse that carries the code entry address. It then stops accepting input until it is reset.

Every accepted byte is echoed back to the serial transmitter. The echo is offered once the transmitter reports that its holding register is empty. While an echo is still outstanding, the block refuses new input, so the sender is paced by the transmit side. The serializers themselves are outside the block. The interface uses byte-valid handshakes: a byte is taken on a clock edge where `rx_valid` and `rx_ready` are both high. The link this block is meant for runs at 8 data bits, no parity, 1 stop bit, with a baud divisor of 6. That setting belongs to the serializer and has no effect on this logic.

Top module: `serial_boot_loader`

## Requirements
- R1: After a synchronous active-low reset, rx_ready is 1 and mem_we, tx_valid, start_pulse and rx_count are all 0.
- R2: The first transaction is written byte by byte to consecutive addresses starting at CODE_BASE. The four prefix bytes come first, in arrival order, and the payload follows them.
- R3: The second transaction is written to consecutive addresses starting at DATA_BASE, laid out the same way as in R2.
- R4: The length prefix is little-endian: the first prefix byte is bits 7:0 and the fourth is bits 31:24. The transaction ends exactly after that many payload bytes.
- R5: A prefix of value zero ends its transaction right after the fourth prefix byte, with no payload.
- R6: Each accepted byte appears on tx_data with tx_valid high, only in cycles where tx_empty is high. The echo is delivered in exactly one such cycle.
- R7: rx_ready is 0 from the cycle after an accepted byte until the cycle after its echo has been delivered.
- R8: rx_count is cleared when the first prefix byte of a transaction is accepted. It counts the payload bytes of that transaction and holds, at completion, the value of the prefix. It changes only after an accepted byte.
- R9: start_pulse is high for exactly one cycle, in the cycle after the final byte of the second transaction is accepted. start_addr equals CODE_BASE.
- R10: After the start pulse, rx_ready stays 0, and offered bytes produce no memory write and no echo until reset.
- R11: mem_we, mem_addr and mem_data for an accepted byte are presented in the cycle right after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte is valid |
| rx_ready | output | 1 | Block can take a byte this cycle |
| tx_empty | input | 1 | Transmit holding register is empty |
| tx_data | output | 8 | Byte to echo |
| tx_valid | output | 1 | Echo byte offered to the transmitter |
| mem_we | output | 1 | Memory byte write enable |
| mem_addr | output | 32 | Memory byte address |
| mem_data | output | 8 | Memory write data |
| rx_count | output | 32 | Payload bytes received in the current transaction |
| start_pulse | output | 1 | One-cycle hand-over pulse |
| start_addr | output | 32 | Code entry address |

## Verification
A wrong prefix index or a wrong byte order in the prefix shows up as a length mismatch. The transaction then ends too early or too late, which is visible on the next write address or on rx_count within one byte. A lost or stuck echo-pending flag shows up on rx_ready and tx_valid in the very next cycle. A region mix-up or a wrong offset is visible on mem_addr one cycle after the byte is accepted. The bench runs a behavioural model next to the design and compares every output on every clock. It also varies the transmitter's emptiness, and it covers multi-byte lengths, zero lengths in each position, and bytes offered after hand-over.

// File: rtl/boot_loader_pkg.sv
// Shared types for the serial boot loader.
package boot_loader_pkg;
    // Framing phase of the current transaction.
    typedef enum logic [1:0] {
        PH_LEN  = 2'd0,   // collecting the length prefix
        PH_PAY  = 2'd1,   // collecting payload bytes
        PH_DONE = 2'd2    // both transactions loaded, input closed
    } bl_phase_e;
endpackage

// File: rtl/bl_echo.sv
// Echo holding stage: captures each accepted byte and offers it to the
// transmitter while the transmitter reports an empty holding register.
// Assumes load_i is never raised while busy_o is high.
module bl_echo #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              tx_empty_i,
    output logic              busy_o,
    output logic              tx_valid_o,
    output logic [DATA_W-1:0] tx_data_o
);
    logic              pend_q;
    logic [DATA_W-1:0] hold_q;

    // Hold one byte until the transmitter has taken it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            hold_q <= '0;
        end else if (load_i) begin
            pend_q <= 1'b1;
            hold_q <= byte_i;
        end else if (pend_q && tx_empty_i) begin
            pend_q <= 1'b0;
        end
    end

    // Offer the held byte only while the transmitter is empty.
    always_comb begin
        busy_o     = pend_q;
        tx_valid_o = pend_q & tx_empty_i;
        tx_data_o  = hold_q;
    end

    // R6: an echo is delivered in a single cycle
    a_r6_echo_once: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o |=> !tx_valid_o);
    // R7: no new byte arrives while an echo is outstanding
    a_r7_no_load_pending: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !load_i);
endmodule

// File: rtl/bl_framer.sv
// Framer: tracks the length prefix and payload of two back-to-back
// transactions, generates byte writes into the code and data regions and
// raises the start pulse once the second transaction is complete.
// Assumes LEN_BYTES is a power of two and acc_i is low once done_o is high.
module bl_framer
    import boot_loader_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          LEN_BYTES = 4,
    parameter logic [31:0] CODE_BASE = 32'h0000_093B,
    parameter logic [31:0] DATA_BASE = 32'h0010_0000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   acc_i,
    input  logic [7:0]             byte_i,
    output logic                   done_o,
    output logic                   mem_we_o,
    output logic [ADDR_W-1:0]      mem_addr_o,
    output logic [7:0]             mem_data_o,
    output logic [8*LEN_BYTES-1:0] count_o,
    output logic                   start_o
);
    localparam int LEN_W = 8 * LEN_BYTES;
    localparam int IDX_W = (LEN_BYTES > 1) ? $clog2(LEN_BYTES) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(LEN_BYTES - 1);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    bl_phase_e         phase_q;
    logic              second_q;
    logic [IDX_W-1:0]  idx_q;
    logic [LEN_W-1:0]  len_q, len_nx, count_q;
    logic [ADDR_W-1:0] offset_q, region_base;
    logic              mem_we_q, start_q, xfer_end;
    logic [ADDR_W-1:0] mem_addr_q;
    logic [7:0]        mem_data_q;

    // Merge the incoming prefix byte into the length, little-endian.
    always_comb begin
        len_nx = (idx_q == '0) ? '0 : len_q;
        len_nx[{idx_q, 3'b000} +: 8] = byte_i;
    end

    // Region select and end-of-transaction detection.
    always_comb begin
        region_base = second_q ? ADDR_W'(DATA_BASE) : ADDR_W'(CODE_BASE);
        xfer_end = acc_i &&
            (((phase_q == PH_LEN) && (idx_q == IDX_LAST) && (len_nx == '0)) ||
             ((phase_q == PH_PAY) && ((count_q + ONE) == len_q)));
    end

    // Framing state, byte writes and hand-over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_LEN;
            second_q   <= 1'b0;
            idx_q      <= '0;
            len_q      <= '0;
            count_q    <= '0;
            offset_q   <= '0;
            mem_we_q   <= 1'b0;
            mem_addr_q <= '0;
            mem_data_q <= '0;
            start_q    <= 1'b0;
        end else begin
            mem_we_q <= acc_i;
            start_q  <= 1'b0;
            if (acc_i) begin
                mem_addr_q <= region_base + offset_q;
                mem_data_q <= byte_i;
                offset_q   <= offset_q + 1'b1;
                if (phase_q == PH_LEN) begin
                    len_q <= len_nx;
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == '0) count_q <= '0;
                    if (idx_q == IDX_LAST) phase_q <= PH_PAY;
                end else if (phase_q == PH_PAY) begin
                    count_q <= count_q + ONE;
                end
            end
            if (xfer_end) begin
                if (!second_q) begin
                    second_q <= 1'b1;
                    phase_q  <= PH_LEN;
                    idx_q    <= '0;
                    offset_q <= '0;
                end else begin
                    phase_q <= PH_DONE;
                    start_q <= 1'b1;
                end
            end
        end
    end

    assign done_o     = (phase_q == PH_DONE);
    assign mem_we_o   = mem_we_q;
    assign mem_addr_o = mem_addr_q;
    assign mem_data_o = mem_data_q;
    assign count_o    = count_q;
    assign start_o    = start_q;

    // R9: the start pulse lasts one cycle
    a_r9_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);
    // R10: nothing is accepted once loading has finished
    a_r10_closed_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !acc_i);
    // R8: the payload count moves only after an accepted byte
    a_r8_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_i |=> $stable(count_o));
    // R11: every accepted byte produces a write in the next cycle
    a_r11_write_follows: assert property (@(posedge clk) disable iff (!rst_n)
        acc_i |=> mem_we_o);
endmodule

// File: rtl/serial_boot_loader.sv
// Top of the serial boot loader: joins the byte handshake, the echo stage
// and the framer. A byte is taken when rx_valid and rx_ready are both high;
// rx_ready drops while an echo is pending and after the hand-over.
module serial_boot_loader #(
    parameter logic [31:0] CODE_BASE = 32'h0000_093B,
    parameter logic [31:0] DATA_BASE = 32'h0010_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  rx_data,
    input  logic        rx_valid,
    output logic        rx_ready,
    input  logic        tx_empty,
    output logic [7:0]  tx_data,
    output logic        tx_valid,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [7:0]  mem_data,
    output logic [31:0] rx_count,
    output logic        start_pulse,
    output logic [31:0] start_addr
);
    logic echo_busy, frame_done, accept;

    // Handshake: accept only when the echo stage is free and input is open.
    always_comb begin
        rx_ready = !echo_busy && !frame_done;
        accept   = rx_valid && rx_ready;
    end

    bl_echo #(.DATA_W(8)) u_echo (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept),
        .byte_i     (rx_data),
        .tx_empty_i (tx_empty),
        .busy_o     (echo_busy),
        .tx_valid_o (tx_valid),
        .tx_data_o  (tx_data)
    );

    bl_framer #(
        .ADDR_W    (32),
        .LEN_BYTES (4),
        .CODE_BASE (CODE_BASE),
        .DATA_BASE (DATA_BASE)
    ) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_i      (accept),
        .byte_i     (rx_data),
        .done_o     (frame_done),
        .mem_we_o   (mem_we),
        .mem_addr_o (mem_addr),
        .mem_data_o (mem_data),
        .count_o    (rx_count),
        .start_o    (start_pulse)
    );

    assign start_addr = CODE_BASE;

    // R7: the cycle after an accepted byte never accepts another
    a_r7_stall_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !rx_ready);
endmodule

// File: tb/serial_boot_loader_test.sv
module serial_boot_loader_test;
    localparam logic [31:0] CB = 32'h0000_093B;
    localparam logic [31:0] DB = 32'h0010_0000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic rx_valid = 1'b0, tx_empty = 1'b1;
    logic rx_ready, tx_valid, mem_we, start_pulse;
    logic [7:0] tx_data, mem_data;
    logic [31:0] mem_addr, rx_count, start_addr;

    serial_boot_loader #(.CODE_BASE(CB), .DATA_BASE(DB)) uut (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .tx_empty(tx_empty), .tx_data(tx_data),
        .tx_valid(tx_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_data(mem_data), .rx_count(rx_count), .start_pulse(start_pulse),
        .start_addr(start_addr));

    always #2 clk = ~clk;   // 250 MHz

    int errs = 0, checks = 0;
    bit busy_mode = 0, starts_seen = 0;
    logic [7:0] mem [int];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on each rising edge.
    bit m_pend, m_done, m_second, m_we, m_start;
    int m_hdr;
    longint m_len, m_cnt, m_off, m_addr;
    logic [7:0] m_txd, m_wd;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = 0; m_done = 0; m_second = 0; m_we = 0; m_start = 0;
            m_hdr = 0; m_len = 0; m_cnt = 0; m_off = 0; m_addr = 0;
            m_txd = 0; m_wd = 0;
        end else begin
            bit acc, fin;
            acc = rx_valid && !m_pend && !m_done;
            m_we = 0; m_start = 0; fin = 0;
            if (m_pend && tx_empty) m_pend = 0;
            if (acc) begin
                m_pend = 1; m_txd = rx_data; m_we = 1; m_wd = rx_data;
                m_addr = (m_second ? DB : CB) + m_off;
                m_off++;
                if (m_hdr < 4) begin
                    if (m_hdr == 0) begin m_len = 0; m_cnt = 0; end
                    m_len = m_len | (longint'(rx_data) << (8 * m_hdr));
                    m_hdr++;
                    if (m_hdr == 4 && m_len == 0) fin = 1;
                end else begin
                    m_cnt++;
                    if (m_cnt == m_len) fin = 1;
                end
                if (fin) begin
                    if (!m_second) begin m_second = 1; m_off = 0; m_hdr = 0; end
                    else begin m_done = 1; m_start = 1; end
                end
            end
        end
    end

    // Compare every output against the model away from the rising edge.
    always @(negedge clk) begin
        chk(rx_ready == (!m_pend && !m_done), "R7 rx_ready", rx_ready, !m_pend && !m_done);
        chk(tx_valid == (m_pend && tx_empty), "R6 tx_valid", tx_valid, m_pend && tx_empty);
        if (m_pend) chk(tx_data == m_txd, "R6 tx_data", tx_data, m_txd);
        chk(mem_we == m_we, "R11 mem_we", mem_we, m_we);
        if (m_we) begin
            chk(mem_addr == 32'(m_addr), "R2/R3 mem_addr", mem_addr, m_addr);
            chk(mem_data == m_wd, "R11 mem_data", mem_data, m_wd);
            mem[int'(mem_addr)] = mem_data;
        end
        chk(rx_count == 32'(m_cnt), "R8 rx_count", rx_count, m_cnt);
        chk(start_pulse == m_start, "R9 start_pulse", start_pulse, m_start);
        if (start_pulse) begin
            starts_seen = 1;
            chk(start_addr == CB, "R9 start_addr", start_addr, CB);
        end
    end

    // Transmitter emptiness: always empty, or busy in a pseudo-random pattern.
    logic [7:0] lfsr = 8'hA5;
    always @(negedge clk) begin
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        tx_empty = busy_mode ? lfsr[0] : 1'b1;
    end

    task automatic send(input logic [7:0] b);
        @(negedge clk); #1;
        rx_valid = 1'b1; rx_data = b;
        while (!rx_ready) begin @(negedge clk); #1; end
        @(negedge clk); #1;
        rx_valid = 1'b0;
    endtask

    function automatic logic [7:0] pay(input int seed, input int i);
        return 8'((seed + i * 7) & 8'hFF);
    endfunction

    task automatic send_xfer(input int len, input int seed);
        for (int k = 0; k < 4; k++) send(8'((len >> (8 * k)) & 8'hFF));
        for (int i = 0; i < len; i++) send(pay(seed, i));
    endtask

    task automatic check_region(input logic [31:0] base, input int len, input int seed, input string req);
        bit ok = 1;
        for (int k = 0; k < 4; k++)
            if (!mem.exists(int'(base) + k) || mem[int'(base) + k] != 8'((len >> (8 * k)) & 8'hFF)) ok = 0;
        for (int i = 0; i < len; i++)
            if (!mem.exists(int'(base) + 4 + i) || mem[int'(base) + 4 + i] != pay(seed, i)) ok = 0;
        chk(ok, req, ok, 1);
    endtask

    task automatic do_reset();
        @(negedge clk); #1; rst_n = 1'b0; rx_valid = 1'b0;
        repeat (3) @(negedge clk);
        #1; rst_n = 1'b1;
        mem.delete();
        starts_seen = 0;
    endtask

    task automatic run(input int l1, input int l2, input bit busy);
        busy_mode = busy;
        do_reset();
        @(negedge clk);
        // R1: state right after reset
        chk(rx_ready && !mem_we && !tx_valid && !start_pulse && rx_count == 0,
            "R1 reset state", {rx_ready, mem_we, tx_valid, start_pulse}, 4'b1000);
        send_xfer(l1, 3);
        repeat (2) @(negedge clk);
        chk(rx_count == 32'(l1), "R8 count after first", rx_count, l1);
        send_xfer(l2, 91);
        repeat (3) @(negedge clk);
        chk(starts_seen, "R9 start seen", starts_seen, 1);
        chk(rx_count == 32'(l2), "R8 count after second", rx_count, l2);
        check_region(CB, l1, 3, "R2/R4 code region");
        check_region(DB, l2, 91, "R3/R4 data region");
        // R10: bytes offered after hand-over are ignored
        begin
            int seen = 0;
            repeat (6) @(negedge clk);
            #1; rx_valid = 1'b1; rx_data = 8'h3C;
            repeat (10) begin
                @(negedge clk);
                if (rx_ready || mem_we || tx_valid || start_pulse) seen++;
            end
            #1; rx_valid = 1'b0;
            chk(seen == 0, "R10 ignored after start", seen, 0);
        end
    endtask

    initial begin
        run(261, 5, 0);   // R4 multi-byte prefix
        run(0, 2, 1);     // R5 zero-length first
        run(1, 0, 1);     // R5 zero-length second
        run(3, 4, 1);
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule